// File: doc/BRIEF.md
# Two-Section Logic Unit Register Slave

This block is the memory-mapped front end of a programmable logic unit with two identical sections, A and B. Each section has a 256-entry lookup RAM, an address register, an input register and an output register. The slave sits on a simple synchronous 16-bit bus that carries a 12-bit byte address, separate write and read strobes, write data, read data and an acknowledge. It decodes a 4 KB page and turns bus accesses into the control signals the two section datapaths use.

Accesses are word wide, so byte address bit 0 is ignored. The address decides which register is reached. For the RAM windows and the address-register windows, the word index comes from address bits [8:1]. A write to an address-register window stores that index, and the data bus is not used. A single offset can point to one register when written and to a different one when read. Every access ends with a one-cycle acknowledge, and read data is valid in the same cycle as the acknowledge.

Top module: `plu_bus_slave`

## Requirements
- R1: A cycle with `bus_wr` or `bus_rd` high at a rising edge causes `bus_ack` to be high for exactly the following cycle. Read data is valid in that acknowledge cycle. Write acknowledges return 0x0000. After reset, `bus_ack` and all registers are 0.
- R2: The control register is at 0x002. It holds wdata[10:0], reads back zero-extended and drives `cfg_q`. Bit 0/1 selects the input for A/B, bit 2/3 selects the output for A/B, bit 4 is stop-mode B, bit 5 is stop-mode A, bit 6 starts A, bit 7 starts B, bit 8/9 forces normal mode for A/B, and bit 10 selects the external clock.
- R3: A write in 0x200–0x3FF (RAM A) or 0x400–0x5FF (RAM B) gives a one-cycle `ram_we_a` or `ram_we_b` pulse in the acknowledge cycle. In that cycle `ram_widx` = addr[8:1] and `ram_wdata` = wdata[7:0], so a write of 0xFF12 at 0x2A0 stores 0x12 at A index 0x50.
- R4: A read in a RAM window drives `ram_raddr` = addr[8:1] during the strobe cycle. It returns {0x00, `ram_rdata_a`/`ram_rdata_b`}.
- R5: A write in 0x600–0x7FF sets `addr_a` to addr[8:1], and a write in 0x800–0x9FF does the same for `addr_b`. The data bus is ignored, so a write at 0x608 stores 4. These windows read as 0x0000.
- R6: A write to 0x00C pulses `swstb_a` and a write to 0x00A pulses `swstb_b`. Each pulse lasts one cycle and coincides with the acknowledge. The write data is ignored.
- R7: A software strobe is suppressed when its section's force-normal bit (cfg bit 8 for A, bit 9 for B) is 1.
- R8: A write to 0x006 loads `out_a` from wdata[7:0], and a write to 0x004 loads `out_b`. A read of 0x006 returns {`out_b`, `out_a`}.
- R9: A read of 0x004 returns {`in_b`, `in_a`} as sampled at the strobe edge.
- R10: The identification words read 0xFAF5 at 0x0FA, 0x0819 at 0x0FC (6-bit maker 000010b above 10-bit type 0000011001b), and {VERSION[3:0], SERIAL[11:0]} at 0x0FE. Writes to them change nothing.
- R11: A read of any unmapped or write-only offset returns 0x0000. A write to an unmapped offset changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| in_a | input | 8 | Section A input register |
| in_b | input | 8 | Section B input register |
| ram_rdata_a | input | 8 | RAM A read data at `ram_raddr` |
| ram_rdata_b | input | 8 | RAM B read data at `ram_raddr` |
| ram_raddr | output | 8 | RAM read index (combinational) |
| ram_we_a | output | 1 | RAM A write pulse |
| ram_we_b | output | 1 | RAM B write pulse |
| ram_widx | output | 8 | RAM write index |
| ram_wdata | output | 8 | RAM write data |
| cfg_q | output | 11 | Control register |
| addr_a | output | 8 | Section A address register |
| addr_b | output | 8 | Section B address register |
| out_a | output | 8 | Section A output register |
| out_b | output | 8 | Section B output register |
| swstb_a | output | 1 | Section A software strobe |
| swstb_b | output | 1 | Section B software strobe |

## Verification
The bench writes to the address-register windows with data that differs from the expected index. A design that took the value from the data bus, or shifted the wrong bits, would then store the wrong value. It reads 0x004 and 0x006 after writing them, and a design that failed to separate the read and write meanings would return the written byte instead of the packed pair. It issues software strobes with each force-normal bit set and cleared, and checks that the pulse lasts one cycle only. Other targets are the top index of each RAM window, control-register bits above bit 10, and writes to identification and unmapped offsets, which would show up as corrupted readback or stray pulses.

// File: rtl/plu_bus_slave.sv
module plu_bus_slave #(
  parameter int VERSION = 1,
  parameter int SERIAL  = 'h123
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_ack,
  input  logic [7:0]  in_a,
  input  logic [7:0]  in_b,
  input  logic [7:0]  ram_rdata_a,
  input  logic [7:0]  ram_rdata_b,
  output logic [7:0]  ram_raddr,
  output logic        ram_we_a,
  output logic        ram_we_b,
  output logic [7:0]  ram_widx,
  output logic [7:0]  ram_wdata,
  output logic [10:0] cfg_q,
  output logic [7:0]  addr_a,
  output logic [7:0]  addr_b,
  output logic [7:0]  out_a,
  output logic [7:0]  out_b,
  output logic        swstb_a,
  output logic        swstb_b
);

  localparam logic [11:0] OFS_CFG   = 12'h002;
  localparam logic [11:0] OFS_REG_B = 12'h004;
  localparam logic [11:0] OFS_REG_A = 12'h006;
  localparam logic [11:0] OFS_STB_B = 12'h00A;
  localparam logic [11:0] OFS_STB_A = 12'h00C;
  localparam logic [11:0] OFS_ID0   = 12'h0FA;
  localparam logic [11:0] OFS_ID1   = 12'h0FC;
  localparam logic [11:0] OFS_ID2   = 12'h0FE;
  localparam logic [15:0] ID_CODE   = 16'hFAF5;
  localparam logic [15:0] ID_MAKER  = {6'b000010, 10'b0000011001};
  localparam logic [15:0] ID_REV    = {VERSION[3:0], SERIAL[11:0]};

  logic [11:0] word;
  logic [7:0]  idx;
  logic        win_ram_a, win_ram_b, win_adr_a, win_adr_b;
  logic [15:0] rd_mux;

  assign word      = {bus_addr[11:1], 1'b0};
  assign idx       = bus_addr[8:1];
  assign ram_raddr = idx;
  assign win_ram_a = bus_addr[11:9] == 3'b001;
  assign win_ram_b = bus_addr[11:9] == 3'b010;
  assign win_adr_a = bus_addr[11:9] == 3'b011;
  assign win_adr_b = bus_addr[11:9] == 3'b100;

  always_comb begin
    rd_mux = 16'h0000;
    if (win_ram_a)      rd_mux = {8'h00, ram_rdata_a};
    else if (win_ram_b) rd_mux = {8'h00, ram_rdata_b};
    else begin
      case (word)
        OFS_CFG:   rd_mux = {5'b0, cfg_q};
        OFS_REG_A: rd_mux = {out_b, out_a};
        OFS_REG_B: rd_mux = {in_b, in_a};
        OFS_ID0:   rd_mux = ID_CODE;
        OFS_ID1:   rd_mux = ID_MAKER;
        OFS_ID2:   rd_mux = ID_REV;
        default:   rd_mux = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 16'h0000;
      ram_we_a  <= 1'b0;
      ram_we_b  <= 1'b0;
      ram_widx  <= 8'h00;
      ram_wdata <= 8'h00;
      cfg_q     <= 11'h000;
      addr_a    <= 8'h00;
      addr_b    <= 8'h00;
      out_a     <= 8'h00;
      out_b     <= 8'h00;
      swstb_a   <= 1'b0;
      swstb_b   <= 1'b0;
    end else begin
      bus_ack   <= bus_wr | bus_rd;
      bus_rdata <= (bus_rd && !bus_wr) ? rd_mux : 16'h0000;
      ram_we_a  <= bus_wr && win_ram_a;
      ram_we_b  <= bus_wr && win_ram_b;
      swstb_a   <= bus_wr && word == OFS_STB_A && !cfg_q[8];
      swstb_b   <= bus_wr && word == OFS_STB_B && !cfg_q[9];
      if (bus_wr) begin
        if (win_ram_a || win_ram_b) begin
          ram_widx  <= idx;
          ram_wdata <= bus_wdata[7:0];
        end
        if (win_adr_a) addr_a <= idx;
        if (win_adr_b) addr_b <= idx;
        if (word == OFS_CFG)   cfg_q <= bus_wdata[10:0];
        if (word == OFS_REG_A) out_a <= bus_wdata[7:0];
        if (word == OFS_REG_B) out_b <= bus_wdata[7:0];
      end
    end
  end

  p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ack);
  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !bus_ack);
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(cfg_q));
  p_ram_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we_a, ram_we_b, swstb_a, swstb_b}));
  p_ram_we_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_a || ram_we_b) |-> bus_ack);
  p_adr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(addr_a) && $stable(addr_b)));
  p_stb_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swstb_a || swstb_b) |-> bus_ack);
  p_stb_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swstb_a |-> !cfg_q[8]) and (swstb_b |-> !cfg_q[9]));
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(out_a) && $stable(out_b)));

endmodule

// File: tb/plu_bus_slave_test.sv
module plu_bus_slave_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  in_a = '0, in_b = '0;
  logic [7:0]  ram_rdata_a, ram_rdata_b, ram_raddr, ram_widx, ram_wdata;
  logic        ram_we_a, ram_we_b, swstb_a, swstb_b;
  logic [10:0] cfg_q;
  logic [7:0]  addr_a, addr_b, out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  mem_a [256];
  logic [7:0]  mem_b [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  plu_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .in_a(in_a), .in_b(in_b), .ram_rdata_a(ram_rdata_a), .ram_rdata_b(ram_rdata_b),
    .ram_raddr(ram_raddr), .ram_we_a(ram_we_a), .ram_we_b(ram_we_b),
    .ram_widx(ram_widx), .ram_wdata(ram_wdata), .cfg_q(cfg_q),
    .addr_a(addr_a), .addr_b(addr_b), .out_a(out_a), .out_b(out_b),
    .swstb_a(swstb_a), .swstb_b(swstb_b));

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = 8'h00;
      mem_b[i] = 8'h00;
    end
  end
  assign ram_rdata_a = mem_a[ram_raddr];
  assign ram_rdata_b = mem_b[ram_raddr];
  always @(posedge clk) begin
    if (ram_we_a) mem_a[ram_widx] <= ram_wdata;
    if (ram_we_b) mem_b[ram_widx] <= ram_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected ack", 16'h1, 16'h0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic acc(input bit wr, input logic [11:0] a, input logic [15:0] d,
                     input logic [15:0] exp_rd, input string req);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    exp_q.push_back(wr ? 16'h0000 : exp_rd);
    tag_q.push_back(req);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ack === 1'b0, "R1 reset ack", {15'b0, bus_ack}, 16'h0);
    chk(cfg_q === 11'h0, "R1 reset cfg", {5'b0, cfg_q}, 16'h0);
    chk({out_b, out_a, addr_b, addr_a} === 32'h0, "R1 reset regs", {out_b, out_a}, 16'h0);
    chk({swstb_a, swstb_b, ram_we_a, ram_we_b} === 4'h0, "R1 reset pulses",
        {12'h0, swstb_a, swstb_b, ram_we_a, ram_we_b}, 16'h0);

    acc(1, 12'h002, 16'h05A5, 0, "R2 cfg write ack");
    chk(cfg_q === 11'h5A5, "R2 cfg port", {5'b0, cfg_q}, 16'h05A5);
    @(negedge clk);
    chk(bus_ack === 1'b0, "R1 ack one cycle", {15'b0, bus_ack}, 16'h0);
    acc(0, 12'h002, 0, 16'h05A5, "R2 cfg readback");
    acc(1, 12'h003, 16'hFFFF, 0, "R2 cfg write odd");
    acc(0, 12'h002, 0, 16'h07FF, "R2 cfg upper bits zero");
    acc(1, 12'h002, 16'h0000, 0, "R2 cfg clear");

    acc(1, 12'h2A0, 16'hFF12, 0, "R3 ram a write");
    chk(ram_we_a === 1'b1 && ram_we_b === 1'b0, "R3 we a", {14'h0, ram_we_a, ram_we_b}, 16'h2);
    chk(ram_widx === 8'h50 && ram_wdata === 8'h12, "R3 idx/data a", {ram_widx, ram_wdata}, 16'h5012);
    @(negedge clk);
    chk(ram_we_a === 1'b0, "R3 we pulse width", {15'h0, ram_we_a}, 16'h0);
    acc(1, 12'h5FE, 16'h0034, 0, "R3 ram b write");
    chk(ram_we_b === 1'b1 && ram_we_a === 1'b0, "R3 we b", {14'h0, ram_we_a, ram_we_b}, 16'h1);
    chk(ram_widx === 8'hFF && ram_wdata === 8'h34, "R3 idx/data b", {ram_widx, ram_wdata}, 16'hFF34);
    acc(0, 12'h2A0, 0, 16'h0012, "R4 ram a read");
    acc(0, 12'h5FE, 0, 16'h0034, "R4 ram b read");
    acc(0, 12'h3FE, 0, 16'h0000, "R4 ram a top index");

    acc(1, 12'h608, 16'hBEEF, 0, "R5 addr a write");
    chk(addr_a === 8'h04, "R5 addr a from address", {8'h0, addr_a}, 16'h0004);
    acc(1, 12'h9FE, 16'h0011, 0, "R5 addr b write");
    chk(addr_b === 8'hFF, "R5 addr b from address", {8'h0, addr_b}, 16'h00FF);
    acc(0, 12'h608, 0, 16'h0000, "R5 addr window reads zero");

    acc(1, 12'h00C, 16'h1234, 0, "R6 strobe a");
    chk(swstb_a === 1'b1 && swstb_b === 1'b0, "R6 strobe a pulse", {14'h0, swstb_a, swstb_b}, 16'h2);
    @(negedge clk);
    chk(swstb_a === 1'b0, "R6 strobe a one cycle", {15'h0, swstb_a}, 16'h0);
    acc(1, 12'h00A, 16'h0000, 0, "R6 strobe b");
    chk(swstb_b === 1'b1 && swstb_a === 1'b0, "R6 strobe b pulse", {14'h0, swstb_a, swstb_b}, 16'h1);

    acc(1, 12'h002, 16'h0100, 0, "R7 force normal a");
    acc(1, 12'h00C, 16'h0000, 0, "R7 strobe a blocked");
    chk(swstb_a === 1'b0, "R7 strobe a suppressed", {15'h0, swstb_a}, 16'h0);
    acc(1, 12'h00A, 16'h0000, 0, "R7 strobe b open");
    chk(swstb_b === 1'b1, "R7 strobe b still works", {15'h0, swstb_b}, 16'h1);
    acc(1, 12'h002, 16'h0200, 0, "R7 force normal b");
    acc(1, 12'h00A, 16'h0000, 0, "R7 strobe b blocked");
    chk(swstb_b === 1'b0, "R7 strobe b suppressed", {15'h0, swstb_b}, 16'h0);

    acc(1, 12'h006, 16'h12AB, 0, "R8 out a write");
    chk(out_a === 8'hAB, "R8 out a", {8'h0, out_a}, 16'h00AB);
    acc(1, 12'h004, 16'h00CD, 0, "R8 out b write");
    chk(out_b === 8'hCD && out_a === 8'hAB, "R8 out b", {out_b, out_a}, 16'hCDAB);
    acc(0, 12'h006, 0, 16'hCDAB, "R8 packed output readback");

    in_a = 8'h3C; in_b = 8'hC3;
    acc(0, 12'h004, 0, 16'hC33C, "R9 packed input readback");
    in_a = 8'h01; in_b = 8'h80;
    acc(0, 12'h004, 0, 16'h8001, "R9 packed input second pattern");

    acc(0, 12'h0FA, 0, 16'hFAF5, "R10 id code");
    acc(0, 12'h0FC, 0, 16'h0819, "R10 id maker/type");
    acc(0, 12'h0FE, 0, 16'h1123, "R10 id version/serial");
    acc(1, 12'h0FA, 16'h0000, 0, "R10 id write");
    acc(0, 12'h0FA, 0, 16'hFAF5, "R10 id unchanged");

    acc(0, 12'h100, 0, 16'h0000, "R11 unmapped read");
    acc(0, 12'hA00, 0, 16'h0000, "R11 unmapped high read");
    acc(0, 12'h00C, 0, 16'h0000, "R11 strobe offset read");
    acc(1, 12'h100, 16'hFFFF, 0, "R11 unmapped write");
    chk({swstb_a, swstb_b, ram_we_a, ram_we_b} === 4'h0, "R11 no pulses",
        {12'h0, swstb_a, swstb_b, ram_we_a, ram_we_b}, 16'h0);
    chk(cfg_q === 11'h200 && out_a === 8'hAB && out_b === 8'hCD, "R11 regs unchanged",
        {out_b, out_a}, 16'hCDAB);
    chk(addr_a === 8'h04 && addr_b === 8'hFF, "R11 addr regs unchanged", {addr_b, addr_a}, 16'hFF04);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 every access acknowledged", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule